// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Flags

This block is a byte-wide register slave that a CPU reaches over a simple synchronous bus. It has two 16-bit down-counters and one level interrupt output. The first counter reloads from its latch and raises a periodic flag. The second counter is loaded once, flags when it first reaches zero, and then keeps decrementing. A prescaler divides the system clock into a one-cycle timer tick. A flag register, an enable register and an auxiliary control register decide which events reach the interrupt pin. Several register accesses have side effects: some reads clear a flag, and some writes load a counter or clear a flag. Two port data registers, two direction registers, an alternate port data register, the shift data register and the peripheral control register are plain storage. Each of them reads back what was last written.

Each counter is driven by a small state machine. The reload counter has two states. In `T1_COUNT` it decrements on each tick. On a tick at zero it goes to `T1_WRAP` and holds 0xFFFF there. The next tick takes it back to `T1_COUNT` with the latch value reloaded. A load from the bus puts it in `T1_COUNT` from either state. The one-shot counter also has two states. A load puts it in `T2_ARMED`. The tick on which it reaches zero moves it to `T2_SPENT`. It keeps counting in both states, and it leaves reset in `T2_SPENT`.

The register index comes from address bits 12 to 9. Read data is registered.

Top module: `dual_interval_timer`

## Requirements
- R1: The register index is `bus_addr[12:9]`. The storage registers keep separate values and read back what was written: port B (0), port A (1), the two direction registers (2, 3), shift data (10), auxiliary control (11), peripheral control (12) and alternate port A (15).
- R2: The timer tick happens once every `TICK_DIV` clocks. A counter value read N·`TICK_DIV` clocks after a tick-aligned load shows exactly N−1 decrements.
- R3: When auxiliary control bits [7:6] equal 01, counter 1 runs latch, latch−1, …, 0, 0xFFFF and then reloads the latch, so one period is latch+2 ticks. Flag bit 6 sets on the tick where the count reaches 0.
- R4: With any other value of auxiliary control bits [7:6], flag bit 6 is never set by counter 1.
- R5: A write to index 4 or 6 changes only the low byte of latch 1. A write to index 7 sets the latch high byte and clears flag bit 6. A write to index 5 does the same as index 7 and also loads counter 1 with the full latch.
- R6: A read of index 4 returns the counter 1 low byte and clears flag bit 6. A read of index 5 returns the high byte and has no side effect. Indexes 6 and 7 return the latch bytes.
- R7: A write to index 8 stores the low latch byte of counter 2 and loads the counter with {0x00, byte}. A write to index 9 loads {byte, low latch}. Counter 2 decrements on each tick and wraps. Flag bit 5 sets once when the count reaches 0 after a load. A read of index 8 clears flag bit 5.
- R8: A one-cycle pulse on `shift_evt` sets flag bit 2. A read of index 10 clears it.
- R9: A write to index 13 clears every flag bit written as 1. A read of index 13 returns the flags in [6:0] and, in bit 7, the OR of the flags that are both set and enabled.
- R10: A write to index 14 with bit 7 = 1 sets the enable bits given in [6:0]. With bit 7 = 0 it clears them. A read of index 14 returns {0, enables}.
- R11: `irq` is high exactly while flag bit 6 or flag bit 2 is both set and enabled. Flag bit 5 never drives `irq`.
- R12: After reset, latch 1 and counter 1 are 0xFFFF, the low latch of counter 2 is 0, counter 2 is 0xFFFF, and the flags and enables are 0.
- R13: If a register write and a timer event fall in the same cycle, the write wins, both for a load and for a flag clear. A flag set wins over a read that clears the same flag.
- R14: A read presents its data on `bus_rdata` on the cycle after the access. The value holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Address bits [12:9], the register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| shift_evt | input | 1 | Completion pulse from an external shifter; sets flag bit 2 |
| irq | output | 1 | Level interrupt request |

## Verification
If a counter phase or latch is wrong, the spacing between flag rises changes. With the default prescaler that shows on `irq` within one period, which is (latch+2)·6 clocks. It also shows on the very next counter read. A lost or spurious side effect, such as a flag not cleared by a read or a load not taken on a tick cycle, shows on the next flag read or on `irq` one clock after the access. The bench keeps a cycle-exact model in lockstep with the design. That lets it catch such a divergence on the first cycle it reaches a port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int IDX_W = 4;

    typedef enum logic [IDX_W-1:0] {
        RI_PORTB   = 4'd0,
        RI_PORTA   = 4'd1,
        RI_DIRB    = 4'd2,
        RI_DIRA    = 4'd3,
        RI_T1CL    = 4'd4,
        RI_T1CH    = 4'd5,
        RI_T1LL    = 4'd6,
        RI_T1LH    = 4'd7,
        RI_T2L     = 4'd8,
        RI_T2H     = 4'd9,
        RI_SHIFT   = 4'd10,
        RI_AUXC    = 4'd11,
        RI_PERC    = 4'd12,
        RI_FLAGS   = 4'd13,
        RI_ENAB    = 4'd14,
        RI_PORTANH = 4'd15
    } reg_idx_e;

    localparam int FLG_SHIFT = 2;
    localparam int FLG_T2    = 5;
    localparam int FLG_T1    = 6;

    localparam logic [1:0] T1_MODE_CONT = 2'b01;

    typedef enum logic {T1_COUNT, T1_WRAP}  t1_phase_e;
    typedef enum logic {T2_ARMED, T2_SPENT} t2_state_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_bypass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] latch,
    output logic [W-1:0] count,
    output logic         wrap,
    output logic         zero_hit
);
    t1_phase_e    phase_q, phase_d;
    logic [W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= T1_COUNT;
            cnt_q   <= '1;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (load) begin
            cnt_d   = load_val;
            phase_d = T1_COUNT;
        end else if (tick) begin
            unique case (phase_q)
                T1_COUNT: begin
                    if (cnt_q == '0) begin
                        cnt_d   = '1;
                        phase_d = T1_WRAP;
                    end else begin
                        cnt_d = cnt_q - W'(1);
                    end
                end
                T1_WRAP: begin
                    cnt_d   = latch;
                    phase_d = T1_COUNT;
                end
            endcase
        end
    end

    always_comb begin
        zero_hit = 1'b0;
        if (tick && !load) begin
            unique case (phase_q)
                T1_COUNT: zero_hit = (cnt_q == W'(1));
                T1_WRAP:  zero_hit = (latch == '0);
            endcase
        end
    end

    assign count = cnt_q;
    assign wrap  = (phase_q == T1_WRAP);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         fire
);
    t2_state_e    st_q, st_d;
    logic [W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= T2_SPENT;
            cnt_q <= '1;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
            st_d  = T2_ARMED;
        end else if (tick) begin
            cnt_d = cnt_q - W'(1);
            unique case (st_q)
                T2_ARMED: if (cnt_q == W'(1)) st_d = T2_SPENT;
                T2_SPENT: st_d = T2_SPENT;
            endcase
        end
    end

    always_comb begin
        fire = 1'b0;
        if (tick && !load) begin
            unique case (st_q)
                T2_ARMED: fire = (cnt_q == W'(1));
                T2_SPENT: fire = 1'b0;
            endcase
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import tmr_pkg::*;
#(
    parameter int TICK_DIV = 6,
    parameter int IDX_LSB  = 9,
    parameter int DATA_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [IDX_LSB+IDX_W-1:IDX_LSB] bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic                          shift_evt,
    output logic                          irq
);
    localparam int TW = 2 * DATA_W;
    localparam int FW = DATA_W - 1;

    reg_idx_e          ridx;
    logic              wr_en, rd_en, tick;
    logic [DATA_W-1:0] pb_q, pa_q, dirb_q, dira_q, sr_q, acr_q, pcr_q, anh_q;
    logic [DATA_W-1:0] t2_lat_q, rdata_q, rd_mux;
    logic [TW-1:0]     t1_latch, t1_count, t2_count, t1_load_val, t2_load_val;
    logic [FW-1:0]     ifr_q, ifr_d, ier_q;
    logic              t1_load, t2_load, t1_wrap, t1_hit, t2_fire;

    assign ridx  = reg_idx_e'(bus_addr);
    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

    assign t1_load     = wr_en && (ridx == RI_T1CH);
    assign t1_load_val = {bus_wdata, t1_latch[DATA_W-1:0]};
    assign t2_load     = wr_en && ((ridx == RI_T2L) || (ridx == RI_T2H));
    assign t2_load_val = (ridx == RI_T2L) ? {{DATA_W{1'b0}}, bus_wdata}
                                          : {bus_wdata, t2_lat_q};

    tick_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    reload_timer #(.W(TW)) u_t1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (t1_load),
        .load_val(t1_load_val),
        .latch   (t1_latch),
        .count   (t1_count),
        .wrap    (t1_wrap),
        .zero_hit(t1_hit)
    );

    oneshot_timer #(.W(TW)) u_t2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (t2_load),
        .load_val(t2_load_val),
        .count   (t2_count),
        .fire    (t2_fire)
    );

    // Plain storage, latches and enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_q     <= '0;
            pa_q     <= '0;
            dirb_q   <= '0;
            dira_q   <= '0;
            sr_q     <= '0;
            acr_q    <= '0;
            pcr_q    <= '0;
            anh_q    <= '0;
            t1_latch <= '1;
            t2_lat_q <= '0;
            ier_q    <= '0;
        end else if (wr_en) begin
            unique case (ridx)
                RI_PORTB:          pb_q     <= bus_wdata;
                RI_PORTA:          pa_q     <= bus_wdata;
                RI_DIRB:           dirb_q   <= bus_wdata;
                RI_DIRA:           dira_q   <= bus_wdata;
                RI_T1CL, RI_T1LL:  t1_latch[DATA_W-1:0]  <= bus_wdata;
                RI_T1CH, RI_T1LH:  t1_latch[TW-1:DATA_W] <= bus_wdata;
                RI_T2L:            t2_lat_q <= bus_wdata;
                RI_SHIFT:          sr_q     <= bus_wdata;
                RI_AUXC:           acr_q    <= bus_wdata;
                RI_PERC:           pcr_q    <= bus_wdata;
                RI_ENAB: begin
                    if (bus_wdata[DATA_W-1]) ier_q <= ier_q | bus_wdata[FW-1:0];
                    else                     ier_q <= ier_q & ~bus_wdata[FW-1:0];
                end
                RI_PORTANH:        anh_q    <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Flags: read clears, then event sets, then write clears (write wins)
    always_comb begin
        ifr_d = ifr_q;
        if (rd_en && ridx == RI_T1CL)  ifr_d[FLG_T1]    = 1'b0;
        if (rd_en && ridx == RI_T2L)   ifr_d[FLG_T2]    = 1'b0;
        if (rd_en && ridx == RI_SHIFT) ifr_d[FLG_SHIFT] = 1'b0;
        if (t1_hit && acr_q[DATA_W-1:DATA_W-2] == T1_MODE_CONT) ifr_d[FLG_T1] = 1'b1;
        if (t2_fire)   ifr_d[FLG_T2]    = 1'b1;
        if (shift_evt) ifr_d[FLG_SHIFT] = 1'b1;
        if (wr_en && (ridx == RI_T1CH || ridx == RI_T1LH)) ifr_d[FLG_T1] = 1'b0;
        if (wr_en && ridx == RI_FLAGS) ifr_d = ifr_d & ~bus_wdata[FW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ifr_q <= '0;
        else        ifr_q <= ifr_d;
    end

    always_comb begin
        unique case (ridx)
            RI_PORTB:   rd_mux = pb_q;
            RI_PORTA:   rd_mux = pa_q;
            RI_DIRB:    rd_mux = dirb_q;
            RI_DIRA:    rd_mux = dira_q;
            RI_T1CL:    rd_mux = t1_count[DATA_W-1:0];
            RI_T1CH:    rd_mux = t1_count[TW-1:DATA_W];
            RI_T1LL:    rd_mux = t1_latch[DATA_W-1:0];
            RI_T1LH:    rd_mux = t1_latch[TW-1:DATA_W];
            RI_T2L:     rd_mux = t2_count[DATA_W-1:0];
            RI_T2H:     rd_mux = t2_count[TW-1:DATA_W];
            RI_SHIFT:   rd_mux = sr_q;
            RI_AUXC:    rd_mux = acr_q;
            RI_PERC:    rd_mux = pcr_q;
            RI_FLAGS:   rd_mux = {|(ifr_q & ier_q), ifr_q};
            RI_ENAB:    rd_mux = {1'b0, ier_q};
            RI_PORTANH: rd_mux = anh_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign irq = (ifr_q[FLG_T1] & ier_q[FLG_T1]) | (ifr_q[FLG_SHIFT] & ier_q[FLG_SHIFT]);
endmodule

// File: rtl/dual_interval_timer_chk.sv
module dual_interval_timer_chk
    import tmr_pkg::*;
#(
    parameter int TICK_DIV = 6,
    parameter int DATA_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [IDX_W-1:0]  bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              tick,
    input logic              t1_load,
    input logic              t1_wrap,
    input logic [2*DATA_W-1:0] t1_count,
    input logic [2*DATA_W-1:0] t1_latch,
    input logic [DATA_W-2:0] ifr_q,
    input logic [DATA_W-2:0] ier_q,
    input logic [DATA_W-1:0] acr_q
);
    generate
        if (TICK_DIV > 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R2
        end
    endgenerate

    AST_T1_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && t1_wrap && !t1_load) |=> (t1_count == $past(t1_latch))); // R3

    AST_T1_FLAG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ifr_q[FLG_T1]) |-> ($past(acr_q[DATA_W-1:DATA_W-2]) == T1_MODE_CONT)); // R4

    AST_T1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        t1_load |=> (t1_count == {$past(bus_wdata), $past(t1_latch[DATA_W-1:0])}) && !t1_wrap); // R5

    AST_FLAG_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == RI_FLAGS) |=>
            ((ifr_q & $past(bus_wdata[DATA_W-2:0])) == '0)); // R13

    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == RI_ENAB && bus_wdata[DATA_W-1]) |=>
            ((ier_q & $past(bus_wdata[DATA_W-2:0])) == $past(bus_wdata[DATA_W-2:0]))); // R10

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ier_q[FLG_T1] && !ier_q[FLG_SHIFT]) |-> !irq); // R11
endmodule

bind dual_interval_timer dual_interval_timer_chk #(
    .TICK_DIV(TICK_DIV),
    .DATA_W  (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .irq      (irq),
    .tick     (tick),
    .t1_load  (t1_load),
    .t1_wrap  (t1_wrap),
    .t1_count (t1_count),
    .t1_latch (t1_latch),
    .ifr_q    (ifr_q),
    .ier_q    (ier_q),
    .acr_q    (acr_q)
);

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, shift_evt = 1'b0;
    logic [12:9] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 1'b0;

    dual_interval_timer #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .shift_evt(shift_evt), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model (from the requirements) ----------------
    int         m_pre;
    logic [15:0] m_t1c, m_t1l, m_t2c;
    logic        m_t1w, m_t2arm, m_rdv;
    logic [7:0]  m_t2l, m_acr, m_pcr, m_sr, m_pb, m_pa, m_db, m_da, m_anh, m_rd;
    logic [6:0]  m_ifr, m_ier;

    function automatic logic exp_irq();
        return |(m_ifr & m_ier & 7'h44);
    endfunction

    function automatic logic [7:0] exp_read(int idx);
        case (idx)
            0: return m_pb;    1: return m_pa;    2: return m_db;   3: return m_da;
            4: return m_t1c[7:0]; 5: return m_t1c[15:8];
            6: return m_t1l[7:0]; 7: return m_t1l[15:8];
            8: return m_t2c[7:0]; 9: return m_t2c[15:8];
            10: return m_sr;   11: return m_acr;  12: return m_pcr;
            13: return {|(m_ifr & m_ier), m_ifr};
            14: return {1'b0, m_ier};
            default: return m_anh;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pre = 0; m_t1c = 16'hFFFF; m_t1l = 16'hFFFF; m_t1w = 1'b0;
            m_t2c = 16'hFFFF; m_t2arm = 1'b0; m_t2l = 0; m_ifr = 0; m_ier = 0;
            m_acr = 0; m_pcr = 0; m_sr = 0; m_pb = 0; m_pa = 0; m_db = 0; m_da = 0;
            m_anh = 0; m_rd = 0; m_rdv = 1'b0;
        end else begin
            logic tk, wr, rd, ld1, ld2, hit1, hit2;
            int idx;
            logic [6:0] nf;
            tk  = (m_pre == DIV-1);
            idx = int'(bus_addr);
            wr  = bus_sel & bus_wr;
            rd  = bus_sel & ~bus_wr;
            m_rdv = rd;
            if (rd) m_rd = exp_read(idx);
            ld1  = wr && idx == 5;
            hit1 = tk && !ld1 && ((!m_t1w && m_t1c == 16'd1) || (m_t1w && m_t1l == 16'd0));
            ld2  = wr && (idx == 8 || idx == 9);
            hit2 = tk && !ld2 && m_t2arm && m_t2c == 16'd1;
            nf = m_ifr;
            if (rd && idx == 4)  nf[6] = 1'b0;
            if (rd && idx == 8)  nf[5] = 1'b0;
            if (rd && idx == 10) nf[2] = 1'b0;
            if (hit1 && m_acr[7:6] == 2'b01) nf[6] = 1'b1;
            if (hit2) nf[5] = 1'b1;
            if (shift_evt) nf[2] = 1'b1;
            if (wr && (idx == 5 || idx == 7)) nf[6] = 1'b0;
            if (wr && idx == 13) nf = nf & ~bus_wdata[6:0];
            // counter 1
            if (ld1) begin m_t1c = {bus_wdata, m_t1l[7:0]}; m_t1w = 1'b0; end
            else if (tk) begin
                if (m_t1w) begin m_t1c = m_t1l; m_t1w = 1'b0; end
                else if (m_t1c == 0) begin m_t1c = 16'hFFFF; m_t1w = 1'b1; end
                else m_t1c = m_t1c - 1;
            end
            // counter 2
            if (ld2) begin
                m_t2c = (idx == 8) ? {8'h00, bus_wdata} : {bus_wdata, m_t2l};
                m_t2arm = 1'b1;
            end else if (tk) begin
                if (hit2) m_t2arm = 1'b0;
                m_t2c = m_t2c - 1;
            end
            if (wr) begin
                case (idx)
                    0: m_pb = bus_wdata;  1: m_pa = bus_wdata;
                    2: m_db = bus_wdata;  3: m_da = bus_wdata;
                    4, 6: m_t1l[7:0]  = bus_wdata;
                    5, 7: m_t1l[15:8] = bus_wdata;
                    8: m_t2l = bus_wdata; 10: m_sr = bus_wdata;
                    11: m_acr = bus_wdata; 12: m_pcr = bus_wdata;
                    14: m_ier = bus_wdata[7] ? (m_ier | bus_wdata[6:0]) : (m_ier & ~bus_wdata[6:0]);
                    15: m_anh = bus_wdata;
                    default: ;
                endcase
            end
            m_ifr = nf;
            m_pre = tk ? 0 : m_pre + 1;
        end
    end

    // ---------------- checking ----------------
    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R11 irq level", int'(irq), int'(exp_irq()));
            if (m_rdv) check("R14 read data", int'(bus_rdata), int'(m_rd));
        end
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        finished = 1'b1;
        $finish;
    endtask

    // Tasks start and end at a falling edge
    task automatic wr_reg(int idx, int val);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'(idx); bus_wdata = 8'(val);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(int idx, output logic [7:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'(idx);
        @(negedge clk);
        bus_sel = 1'b0;
        v = bus_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq(output int when);
        int n;
        n = 0;
        while (!irq && n < 1000) begin @(negedge clk); n++; end
        when = cyc;
    endtask

    initial begin
        int t0, t1;
        logic [7:0] v;
        #(CLK_PERIOD * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        int t0, t1;
        logic [7:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset values
        rd_reg(6, v);  check("R12 latch1 low", v, 8'hFF);
        rd_reg(7, v);  check("R12 latch1 high", v, 8'hFF);
        rd_reg(14, v); check("R12 enables", v, 8'h00);
        rd_reg(13, v); check("R12 flags", v, 8'h00);
        rd_reg(9, v);  check("R12 counter2 high", v, 8'hFF);
        check("R12 irq", irq, 0);

        // R1 storage and index decode
        wr_reg(0, 8'h5A); wr_reg(1, 8'hA5); wr_reg(15, 8'h3C);
        wr_reg(2, 8'h0F); wr_reg(3, 8'hF0); wr_reg(12, 8'h99);
        rd_reg(0, v);  check("R1 port B", v, 8'h5A);
        rd_reg(1, v);  check("R1 port A", v, 8'hA5);
        rd_reg(15, v); check("R1 alt port A", v, 8'h3C);
        rd_reg(2, v);  check("R1 dir B", v, 8'h0F);
        rd_reg(3, v);  check("R1 dir A", v, 8'hF0);
        rd_reg(12, v); check("R1 periph ctrl", v, 8'h99);
        idle(3);
        check("R14 read data held", bus_rdata, 8'h99);

        // R10 enable set/clear
        wr_reg(14, 8'hC4); rd_reg(14, v); check("R10 enable set", v, 8'h44);
        wr_reg(14, 8'h04); rd_reg(14, v); check("R10 enable clear", v, 8'h40);

        // R5 / R3 / R6 continuous period
        wr_reg(4, 8'h03); wr_reg(5, 8'h00);
        wr_reg(11, 8'h40); wr_reg(13, 8'h7F);
        wait_irq(t0);
        check("R3 first flag", irq, 1);
        rd_reg(4, v);
        rd_reg(13, v); check("R6 low read clears flag", v[6], 0);
        wait_irq(t1);
        check("R3 period latch+2 ticks", t1 - t0, 5 * DIV);
        rd_reg(5, v);
        rd_reg(13, v); check("R6 high read keeps flag", v[6], 1);
        check("R9 summary bit", v[7], 1);
        wr_reg(7, 8'h00);
        rd_reg(13, v); check("R5 latch-high write clears flag", v[6], 0);
        wr_reg(6, 8'h07);
        rd_reg(6, v); check("R5 low latch write", v, 8'h07);
        rd_reg(7, v); check("R5 high latch kept", v, 8'h00);

        // R4 other mode
        wr_reg(11, 8'h00); wr_reg(13, 8'h7F);
        idle(80);
        rd_reg(13, v); check("R4 no flag outside continuous", v[6], 0);

        // R13 load wins on a tick cycle
        wr_reg(4, 8'h10);
        while (m_pre != DIV-1) @(negedge clk);
        wr_reg(5, 8'h00);
        rd_reg(4, v); check("R13 load beats tick", v, 8'h10);

        // R2 tick spacing via counter 2
        while (m_pre != DIV-1) @(negedge clk);
        wr_reg(9, 8'h01);
        idle(59);
        rd_reg(8, v); check("R2 decrements per tick", v, 8'hF7);

        // R7 one-shot flag, R11 no irq from it
        wr_reg(14, 8'hA0); wr_reg(8, 8'h04);
        idle(40);
        rd_reg(13, v); check("R7 counter2 flag", v[5], 1);
        check("R9 summary includes enabled bit5", v[7], 1);
        check("R11 bit5 no irq", irq, 0);
        rd_reg(8, v);
        rd_reg(13, v); check("R7 read clears flag", v[5], 0);
        idle(60);
        rd_reg(13, v); check("R7 fires once", v[5], 0);

        // R8 shift flag
        wr_reg(14, 8'h84);
        shift_evt = 1'b1; @(negedge clk); shift_evt = 1'b0;
        check("R8 shift flag irq", irq, 1);
        wr_reg(10, 8'h3C);
        rd_reg(10, v); check("R8 shift data", v, 8'h3C);
        check("R8 read clears", irq, 0);
        shift_evt = 1'b1; @(negedge clk); shift_evt = 1'b0;
        wr_reg(13, 8'h04); check("R9 write clears flag", irq, 0);

        // Random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            int idx;
            idx = int'($urandom_range(0, 15));
            bus_sel   = ($urandom_range(0, 2) != 0);
            bus_wr    = $urandom_range(0, 1) == 1;
            bus_addr  = 4'(idx);
            if (idx == 5 || idx == 7 || idx == 9) bus_wdata = 8'($urandom_range(0, 1));
            else if (idx == 4 || idx == 6 || idx == 8) bus_wdata = 8'($urandom_range(0, 15));
            else if (idx == 11) bus_wdata = ($urandom_range(0, 1) == 1) ? 8'h40 : 8'($urandom);
            else bus_wdata = 8'($urandom);
            shift_evt = ($urandom_range(0, 39) == 0);
            @(negedge clk);
        end
        bus_sel = 1'b0; shift_evt = 1'b0;
        idle(2);
        report();
    end
endmodule